// File: doc/BRIEF.md
# Stepped Frequency Sweep Sequencer

This block steps a frequency word across a programmed span in a fixed number of equal
increments, fifty by default. A timer supplies tick pulses. An internal divider groups
those ticks so that one step takes a programmable number of them, which sets the total
sweep time. On every step the block raises a binary step code that drives a
binary-weighted DAC, which produces an analog staircase. In the same cycle the block
presents the frequency word for that step, computed exactly as base plus step times span
divided by the step count.

A sweep begins when a start request arrives while the block is idle. At that moment the
block captures the base frequency, the span and the tick period. A sweep must stay inside
one frequency subrange, which is the set of words that share the bits above a parameter
position. A request whose end frequency leaves the subrange of its base is refused with a
one-cycle error pulse. When the code reaches the final step, a one-cycle done pulse
marks it. The code then falls back to zero, and the block either starts the next pass or
returns to idle.

Top module: `sweep_sequencer`

## Requirements
- R1: After reset the step code is 0, the frequency word is 0, and busy, done and err are all low.
- R2: A start pulse seen while idle, with a request that fits its subrange, makes busy high at the next edge, with step code 0 and frequency word equal to the requested base.
- R3: A start pulse seen while idle is refused when base plus span overflows the 24-bit word, or when the sum differs from the base in bits 23..16. A refused start raises err for exactly one cycle and leaves busy low.
- R4: While running, the step code rises by exactly one after every N accepted ticks, where N is the captured period and a period of 0 acts as 1. Cycles without a tick leave the code unchanged.
- R5: At every step k the frequency word equals base + floor(k × span / 50), so step 50 shows exactly base + span.
- R6: done is high for exactly the one cycle in which the step code shows 50.
- R7: In the cycle after done, the step code is 0 and the word equals the base. Busy stays high only if repeat_i was high in the done cycle. A tick in the done cycle is not counted.
- R8: A start pulse while busy, including the done cycle, has no effect. Base, span and period inputs that change during a sweep do not alter it.
- R9: The step code never exceeds 50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sweep start request |
| repeat_i | input | 1 | Start another pass after the final step |
| tick_i | input | 1 | Timer pulse, one cycle wide |
| start_freq_i | input | 24 | Base frequency word |
| span_i | input | 24 | Frequency span of the sweep |
| period_i | input | 16 | Ticks per step |
| step_o | output | 6 | Step code for the weighted DAC |
| freq_o | output | 24 | Frequency word of the current step |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Final step reached (one cycle) |
| err_o | output | 1 | Start refused, outside subrange (one cycle) |

## Verification
Two events can land on the same edge. One is a new start request or a timer tick. The
other is the final-step cycle, in which done is high and the block decides between a
new pass and idle. The bench drives start high on purpose in every done cycle, and lets
random ticks fall there as well. It then checks that the code wraps to 0 and that the
word returns to the base. Busy must then follow only the repeat input sampled in that
cycle, and the ignored tick must not shorten the first step of the next pass.

// File: rtl/sweep_pkg.sv
`timescale 1ns/1ps
package sweep_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_LAST = 2'd2
    } sweep_phase_e;
endpackage

// File: rtl/sweep_range_chk.sv
`timescale 1ns/1ps
// Decides whether base + span stays inside the subrange of base.
module sweep_range_chk #(
    parameter int FREQ_W    = 24,
    parameter int SUB_SHIFT = 16
) (
    input  logic [FREQ_W-1:0] base_i,
    input  logic [FREQ_W-1:0] span_i,
    output logic              fits_o
);
    logic [FREQ_W:0] end_w;

    always_comb begin
        end_w  = {1'b0, base_i} + {1'b0, span_i};
        fits_o = !end_w[FREQ_W]
              && (end_w[FREQ_W-1:SUB_SHIFT] == base_i[FREQ_W-1:SUB_SHIFT]);
    end
endmodule

// File: rtl/sweep_freq_calc.sv
`timescale 1ns/1ps
// Exact word for a given step: base + floor(step * span / STEPS).
module sweep_freq_calc #(
    parameter int FREQ_W = 24,
    parameter int STEPS  = 50,
    parameter int STEP_W = 6
) (
    input  logic [FREQ_W-1:0] base_i,
    input  logic [FREQ_W-1:0] span_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [FREQ_W-1:0] word_o
);
    localparam int PROD_W = FREQ_W + STEP_W;

    logic [PROD_W-1:0] prod_w;
    logic [PROD_W-1:0] frac_w;
    logic              unused_frac_hi;

    always_comb begin
        prod_w = PROD_W'(span_i) * PROD_W'(step_i);
        frac_w = prod_w / PROD_W'(STEPS);
        word_o = base_i + frac_w[FREQ_W-1:0];
    end

    assign unused_frac_hi = ^frac_w[PROD_W-1:FREQ_W];
endmodule

// File: rtl/sweep_tick_div.sv
`timescale 1ns/1ps
// Groups timer ticks: one advance per PERIOD ticks (0 behaves as 1).
module sweep_tick_div #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [PER_W-1:0] period_i,
    output logic             adv_o
);
    logic [PER_W-1:0] cnt_d, cnt_q;
    logic [PER_W:0]   eff_w;
    logic [PER_W:0]   nxt_w;

    always_comb begin
        eff_w = (period_i == '0) ? (PER_W+1)'(1) : {1'b0, period_i};
        nxt_w = {1'b0, cnt_q} + (PER_W+1)'(1);
        adv_o = tick_i && (nxt_w >= eff_w);
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = adv_o ? '0 : nxt_w[PER_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the tick count always stays below the effective period
    a_r4_cnt_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt_q} < eff_w);
endmodule

// File: rtl/sweep_sequencer.sv
`timescale 1ns/1ps
module sweep_sequencer
    import sweep_pkg::*;
#(
    parameter int FREQ_W    = 24,
    parameter int STEPS     = 50,
    parameter int PER_W     = 16,
    parameter int SUB_SHIFT = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          repeat_i,
    input  logic                          tick_i,
    input  logic [FREQ_W-1:0]             start_freq_i,
    input  logic [FREQ_W-1:0]             span_i,
    input  logic [PER_W-1:0]              period_i,
    output logic [$clog2(STEPS+1)-1:0]    step_o,
    output logic [FREQ_W-1:0]             freq_o,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          err_o
);
    localparam int STEP_W = $clog2(STEPS + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS);

    typedef struct packed {
        sweep_phase_e      phase;
        logic [STEP_W-1:0] step;
        logic [FREQ_W-1:0] freq;
        logic [FREQ_W-1:0] base;
        logic [FREQ_W-1:0] span;
        logic [PER_W-1:0]  period;
        logic              done;
        logic              err;
    } seq_t;

    seq_t d, q;

    logic              fits_w;
    logic              load_w;
    logic              adv_w;
    logic              run_tick_w;
    logic              div_clr_w;
    logic [STEP_W-1:0] step_nx_w;
    logic [FREQ_W-1:0] freq_nx_w;

    sweep_range_chk #(
        .FREQ_W   (FREQ_W),
        .SUB_SHIFT(SUB_SHIFT)
    ) u_range (
        .base_i(start_freq_i),
        .span_i(span_i),
        .fits_o(fits_w)
    );

    sweep_tick_div #(
        .PER_W(PER_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (div_clr_w),
        .tick_i  (run_tick_w),
        .period_i(q.period),
        .adv_o   (adv_w)
    );

    sweep_freq_calc #(
        .FREQ_W(FREQ_W),
        .STEPS (STEPS),
        .STEP_W(STEP_W)
    ) u_calc (
        .base_i(q.base),
        .span_i(q.span),
        .step_i(step_nx_w),
        .word_o(freq_nx_w)
    );

    always_comb begin
        load_w     = (q.phase == PH_IDLE) && start_i && fits_w;
        run_tick_w = (q.phase == PH_RUN) && tick_i;
        div_clr_w  = load_w || (q.phase == PH_LAST);
        step_nx_w  = q.step + STEP_W'(1);

        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    if (fits_w) begin
                        d.phase  = PH_RUN;
                        d.base   = start_freq_i;
                        d.span   = span_i;
                        d.period = period_i;
                        d.step   = '0;
                        d.freq   = start_freq_i;
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            PH_RUN: begin
                if (adv_w) begin
                    d.step = step_nx_w;
                    d.freq = freq_nx_w;
                    if (step_nx_w == LAST_STEP) begin
                        d.phase = PH_LAST;
                        d.done  = 1'b1;
                    end
                end
            end
            PH_LAST: begin
                d.step  = '0;
                d.freq  = q.base;
                d.phase = repeat_i ? PH_RUN : PH_IDLE;
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign step_o = q.step;
    assign freq_o = q.freq;
    assign busy_o = (q.phase != PH_IDLE);
    assign done_o = q.done;
    assign err_o  = q.err;

    // R9: code bounded by the step count
    a_r9_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        step_o <= LAST_STEP);
    // R6: done only together with the final code
    a_r6_done_with_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (step_o == LAST_STEP));
    // R7: the final code lasts one cycle, then wraps to zero at the base
    a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (step_o == '0 && freq_o == q.base));
    // R4: the code moves by at most one per cycle while running
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=>
            (step_o == $past(step_o) || step_o == $past(step_o) + STEP_W'(1)));
    // R3: a refused start never leaves the block busy
    a_r3_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o);
    // R2: a new sweep begins at step zero on the base word
    a_r2_start_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (step_o == '0 && freq_o == q.base));
    // R5: the last step lands exactly on base + span
    a_r5_final_word: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step_o == LAST_STEP) |-> (freq_o == q.base + q.span));
    // R8: captured settings hold while a sweep continues
    a_r8_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || ($stable(q.base) && $stable(q.span) && $stable(q.period))));
endmodule

// File: tb/sim_sweep_sequencer.sv
`timescale 1ns/1ps
module sim_sweep_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        repeat_i = 1'b0;
    logic        tick_i = 1'b0;
    logic [23:0] start_freq_i = '0;
    logic [23:0] span_i = '0;
    logic [15:0] period_i = '0;
    logic [5:0]  step_o;
    logic [23:0] freq_o;
    logic        busy_o, done_o, err_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sweep_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .repeat_i(repeat_i),
        .tick_i(tick_i), .start_freq_i(start_freq_i), .span_i(span_i),
        .period_i(period_i), .step_o(step_o), .freq_o(freq_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint expf(longint s, longint sp, longint st);
        return s + (st * sp) / 50;
    endfunction

    task automatic run_sweep(input logic [23:0] s, input logic [23:0] sp,
                             input logic [15:0] per, input int passes, input int gap);
        int     left;
        int     es;
        int     ecnt;
        int     pe;
        logic   ebusy;
        logic   edone;
        left = passes;
        pe   = (per == 0) ? 1 : int'(per);
        @(negedge clk);
        start_freq_i = s; span_i = sp; period_i = per;
        start_i = 1'b1; tick_i = 1'b0; repeat_i = (left > 0);
        @(posedge clk); #1;
        chk("R2", "busy", busy_o, 1);
        chk("R2", "step", step_o, 0);
        chk("R2", "freq", freq_o, s);
        chk("R2", "err", err_o, 0);
        es = 0; ecnt = 0; ebusy = 1'b1; edone = 1'b0;
        while (ebusy) begin
            @(negedge clk);
            // R8: start during a sweep, forced in every done cycle
            start_i      = edone ? 1'b1 : (($urandom % 8) == 0);
            start_freq_i = 24'($urandom);
            span_i       = 24'($urandom);
            period_i     = 16'($urandom);
            tick_i       = (($urandom % gap) == 0);
            repeat_i     = (left > 0);
            @(posedge clk); #1;
            if (edone) begin
                es = 0; ecnt = 0; edone = 1'b0;
                ebusy = (left > 0);
                if (left > 0) left--;
                chk("R7", "wrap step", step_o, 0);
                chk("R7", "wrap freq", freq_o, s);
                chk("R8", "busy after done-cycle start", busy_o, ebusy);
            end else if (tick_i) begin
                if (ecnt + 1 >= pe) begin
                    es++; ecnt = 0; edone = (es == 50);
                end else begin
                    ecnt++;
                end
            end
            chk("R4", "step", step_o, es);
            chk("R5", "freq", freq_o, expf(s, sp, es));
            chk("R6", "done", done_o, edone);
            chk("R9", "step bound", (step_o <= 50), 1);
            if (!edone) chk("R8", "busy", busy_o, ebusy);
        end
        @(negedge clk);
        start_i = 1'b0; tick_i = 1'b0; repeat_i = 1'b0;
    endtask

    task automatic try_bad(input logic [23:0] s, input logic [23:0] sp);
        @(negedge clk);
        start_freq_i = s; span_i = sp; start_i = 1'b1;
        @(posedge clk); #1;
        chk("R3", "err pulse", err_o, 1);
        chk("R3", "busy", busy_o, 0);
        @(negedge clk);
        start_i = 1'b0;
        @(posedge clk); #1;
        chk("R3", "err one cycle", err_o, 0);
        chk("R3", "busy stays low", busy_o, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "step", step_o, 0);
        chk("R1", "freq", freq_o, 0);
        chk("R1", "busy", busy_o, 0);
        chk("R1", "done", done_o, 0);
        chk("R1", "err", err_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners
        run_sweep(24'h030000, 24'h00FFFF, 16'd1, 0, 1);   // widest span that fits
        run_sweep(24'h120345, 24'h000000, 16'd0, 0, 2);   // zero span, period 0
        run_sweep(24'h0A1000, 24'h000031, 16'd3, 1, 2);   // span below step count, one repeat
        try_bad(24'h00FFF0, 24'h000020);                   // crosses subrange
        try_bad(24'hFFFF00, 24'h000200);                   // overflows the word
        run_sweep(24'h04FF00, 24'h0000FF, 16'd2, 0, 3);   // ends on the last word of subrange

        // Random sweeps
        for (int i = 0; i < 5; i++) begin
            logic [23:0] s;
            logic [23:0] sp;
            s  = 24'($urandom);
            sp = 24'($urandom % (32'h10000 - {16'h0, s[15:0]}));
            run_sweep(s, sp, 16'($urandom % 5), int'($urandom % 2), 1 + int'($urandom % 3));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #750us;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule